// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block drives the address of a synchronous pipelined memory during a four-beat burst. A load strobe captures a full address from outside, and that address is the first beat. Each advance strobe then moves to the next beat. The block computes the second, third and fourth addresses itself. Only the two lowest address bits change during a burst. The bits above them keep the value that was loaded.

The order of the beats depends on an order-select input, which is sampled together with the load. A low select gives linear order, in which the low bits count upward from the start value and wrap modulo four. A high select gives interleaved order, in which the low bits of each beat are the start bits XORed with the beat number. After the fourth beat, a further advance returns to the first address, and the same four addresses repeat. A last-beat flag marks the fourth beat. The outputs are registered state, so each change shows one cycle after the strobe that causes it.

Top module: `bseq_top`

## Requirements
- R1: While reset is active and in the first cycle after it, `addr_o` is all zeros and `last_o` is 0.
- R2: One cycle after `load_i` is high, `addr_o` equals the `addr_i` value sampled with the load and `last_o` is 0. This holds even when `adv_i` is high in the same cycle, because load wins over advance.
- R3: `order_i` is sampled only in load cycles. A value of 0 selects linear order and a value of 1 selects interleaved order. Changing `order_i` between loads does not change the sequence on `addr_o`.
- R4: In linear order, beat k (k = 0..3) puts (start + k) mod 4 on `addr_o[1:0]`, where start is the loaded `addr_i[1:0]`.
- R5: In interleaved order, beat k puts start XOR k on `addr_o[1:0]`.
- R6: Between loads, `addr_o[ADDR_W-1:2]` stays equal to the loaded `addr_i[ADDR_W-1:2]`.
- R7: Each cycle with `adv_i` high and `load_i` low moves forward exactly one beat. A cycle with both strobes low leaves `addr_o` and `last_o` unchanged.
- R8: `last_o` is 1 exactly while the beat index is 3, which is the fourth address of the burst.
- R9: An advance from beat 3 returns to beat 0, so `addr_o` again equals the loaded address, and the four-address sequence repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture `addr_i` and `order_i`; beat index goes to 0 |
| adv_i | input | 1 | Step to the next beat of the burst |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External first address |
| addr_o | output | ADDR_W | Current burst address |
| last_o | output | 1 | High on the fourth beat |

## Verification
On every cycle, the assertions check these rules:
- a load produces the loaded address with the flag low;
- the upper bits hold between loads;
- an idle cycle changes nothing;
- an advance moves exactly one beat;
- an advance from the fourth beat returns to the start bits;
- the low bits equal the start bits only on beat zero.

The actual linear and interleaved orders for each of the four start values can only be shown by the bench scenarios, which compare every beat with a reference function. The same applies to the rule that a mode change in the middle of a burst has no effect.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    localparam int BEATS = 4;
    localparam int IDX_W = $clog2(BEATS);

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
    import bseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             last;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    // Next-state logic: load wins over advance; the index wraps after the last beat.
    always_comb begin
        ctr_d = ctr_q;
        if (load_i) begin
            ctr_d.idx = '0;
        end else if (adv_i) begin
            ctr_d.idx = ctr_q.idx + 1'b1;
        end
        ctr_d.last = (ctr_d.idx == IDX_W'(BEATS - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign idx_o  = ctr_q.idx;
    assign last_o = ctr_q.last;

    // R7: an advance without a load moves the index forward by exactly one.
    p_adv_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (ctr_q.idx == IDX_W'($past(ctr_q.idx) + 1'b1)));

    // R2: a load always restarts the beat index.
    p_load_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (ctr_q.idx == '0));

    // R8: the last-beat flag only rises after an advance.
    p_last_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(last_o) |-> ($past(adv_i) && !$past(load_i)));
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
    import bseq_pkg::*;
(
    input  logic [IDX_W-1:0] start_i,
    input  logic [IDX_W-1:0] idx_i,
    input  order_e           order_i,
    output logic [IDX_W-1:0] lo_o
);
    // Maps the start bits and the beat index to the current low address bits.
    always_comb begin
        unique case (order_i)
            ORD_INTERLEAVE: lo_o = start_i ^ idx_i;
            default:        lo_o = start_i + idx_i;
        endcase
    end

    // R4 / R5: both orders are permutations, so the low bits equal the start bits only on beat 0.
    always_comb begin
        if (!$isunknown({start_i, idx_i, order_i})) begin
            a_beat0_only_r4: assert ((idx_i == '0) == (lo_o == start_i));
        end
    end
endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam int HI_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [IDX_W-1:0] start;
        order_e           order;
    } base_t;

    base_t            base_d, base_q;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] lo;

    // The address and the order are captured only in a load cycle.
    always_comb begin
        base_d = base_q;
        if (load_i) begin
            base_d.hi    = addr_i[ADDR_W-1:IDX_W];
            base_d.start = addr_i[IDX_W-1:0];
            base_d.order = order_e'(order_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '{hi: '0, start: '0, order: ORD_LINEAR};
        else        base_q <= base_d;
    end

    bseq_beat_ctr i_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .adv_i  (adv_i),
        .idx_o  (idx),
        .last_o (last_o)
    );

    bseq_order_map i_map (
        .start_i (base_q.start),
        .idx_i   (idx),
        .order_i (base_q.order),
        .lo_o    (lo)
    );

    assign addr_o = {base_q.hi, lo};

    // R2: a load shows the captured address and clears the last-beat flag.
    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ((addr_o == $past(addr_i)) && !last_o));

    // R6: without a load the upper bits never move.
    p_hi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (addr_o[ADDR_W-1:IDX_W] == $past(addr_o[ADDR_W-1:IDX_W])));

    // R7: an idle cycle changes nothing.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> ($stable(addr_o) && $stable(last_o)));

    // R9: an advance from the fourth beat returns to the start bits.
    p_wrap_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && adv_i && !load_i) |=> ((addr_o[IDX_W-1:0] == $past(base_q.start)) && !last_o));
endmodule

// File: tb/test_bseq_top.sv
module test_bseq_top;
    localparam int ADDR_W = 16;
    localparam int HI_W   = ADDR_W - 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic              adv_i = 1'b0;
    logic              order_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic              last_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    logic [HI_W-1:0] m_hi = '0;
    logic [1:0]      m_start = '0;
    logic            m_order = 1'b0;
    logic [1:0]      m_k = '0;

    always #2 clk = ~clk;

    bseq_top #(.ADDR_W(ADDR_W)) i_bseq_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_i   (adv_i),
        .order_i (order_i),
        .addr_i  (addr_i),
        .addr_o  (addr_o),
        .last_o  (last_o)
    );

    function automatic logic [1:0] exp_lo(logic [1:0] s, logic [1:0] k, logic ord);
        return ord ? (s ^ k) : 2'(s + k);
    endfunction

    task automatic chk(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Checks every output against the model; tag names the requirement behind the low bits.
    task automatic check_all(string tag);
        chk(tag, ADDR_W'(addr_o[1:0]), ADDR_W'(exp_lo(m_start, m_k, m_order)));
        chk("R6", ADDR_W'(addr_o[ADDR_W-1:2]), ADDR_W'(m_hi));
        chk("R8", ADDR_W'(last_o), ADDR_W'(m_k == 2'd3));
    endtask

    // Drives one cycle of stimulus, updates the model, and samples at the next falling edge.
    task automatic step(logic ld, logic adv, logic ord, logic [ADDR_W-1:0] a, string tag);
        load_i  = ld;
        adv_i   = adv;
        order_i = ord;
        addr_i  = a;
        if (ld) begin
            m_hi    = a[ADDR_W-1:2];
            m_start = a[1:0];
            m_order = ord;
            m_k     = '0;
        end else if (adv) begin
            m_k = m_k + 2'd1;
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] a;
        string tag;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", addr_o, '0);
        chk("R1", ADDR_W'(last_o), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", addr_o, '0);
        chk("R1", ADDR_W'(last_o), '0);

        // Every start value in both orders: full burst, wrap, and one more beat.
        for (int ord = 0; ord < 2; ord++) begin
            for (int s = 0; s < 4; s++) begin
                a = {HI_W'($urandom), 2'(s)};
                tag = (ord != 0) ? "R5" : "R4";
                step(1'b1, 1'b0, 1'(ord), a, "R2");
                chk("R2", addr_o, a);
                for (int b = 0; b < 3; b++) step(1'b0, 1'b1, 1'(ord), a, tag);
                step(1'b0, 1'b1, 1'(ord), '0, "R9");
                chk("R9", addr_o, a);
                step(1'b0, 1'b1, 1'(ord), '0, "R9");
            end
        end

        // Load and advance together: the load wins.
        step(1'b0, 1'b1, 1'b0, '0, "R7");
        step(1'b1, 1'b1, 1'b0, 16'hA5A6, "R2");
        chk("R2", addr_o, 16'hA5A6);

        // Flipping the order input mid-burst has no effect.
        step(1'b1, 1'b0, 1'b1, 16'h1231, "R3");
        step(1'b0, 1'b1, 1'b0, 16'h0000, "R3");
        chk("R3", addr_o, 16'h1230);
        step(1'b0, 1'b1, 1'b0, 16'hFFFF, "R3");
        chk("R3", addr_o, 16'h1233);

        // Idle cycles hold the address while inputs move.
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, 1'(i), ADDR_W'($urandom), "R7");
            chk("R7", addr_o, 16'h1233);
        end

        // Constrained random mix.
        for (int i = 0; i < 3000; i++) begin
            logic ld, adv, ord;
            ld  = ($urandom_range(7) == 0);
            adv = ($urandom_range(1) == 1);
            ord = 1'($urandom);
            tag = m_order ? "R5" : "R4";
            step(ld, adv, ord, ADDR_W'($urandom), ld ? "R2" : tag);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule